// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks one frame of a linear framebuffer in memory and issues the read-address requests that a display pipeline needs to fetch it. A pulse from the display timing generator starts a frame. The block then captures the frame configuration: the start address, the number of bytes to fetch on each line, the address step between line starts, and the number of lines. It steps through every line in bursts of a selectable size. Each request stays on a simple valid/grant channel until the bus accepts it. A one-cycle strobe returns the completion of each accepted request.

Software pans the visible window by writing a different start address. The block picks that address up only at the next frame-start pulse, so a frame that is already being fetched stays consistent. A cap on the number of accepted requests that have not yet completed keeps the downstream data buffer from being overrun. The block reports two interrupt events. One marks the end of the frame fetch. The other marks a bus error, which also ends the fetch early.

Top module: `fb_scan_fetch`

## Requirements
- R1: After reset, `req_valid` is low, both `evt` bits are low, and the block waits for `frame_start`.
- R2: `cfg_base` is captured only on a `frame_start` pulse accepted while idle. Changing `cfg_base` during a fetch has no effect on that fetch, and the next frame uses the new value.
- R3: Line k starts at base + k × `cfg_pitch`. Within a line, each request address follows the previous one by the bytes it requested, and each line fetches exactly `cfg_line_len` bytes, where `cfg_line_len` is a multiple of the beat size, 2^BEAT_SH bytes.
- R4: A frame fetches `cfg_line_cnt` + 1 lines.
- R5: The burst length comes from the one-hot field `cfg_bus_opt[4:0]`: bit0 = 1 beat, bit1 = 2, bit2 = 4, bit3 = 8, bit4 = 16. When several bits are set, the highest one wins. All zero means single beats.
- R6: The last request of a line is shortened to the beats that remain in the line, so no request reaches past the line length.
- R7: The number of accepted requests not yet completed never exceeds `cfg_bus_opt[11:8]`. A value of 0 is treated as 1. Each `rsp_valid` strobe completes one request.
- R8: While `req_valid` is high and `req_grant` is low, `req_addr` and `req_beats` hold their values, unless an error response arrives.
- R9: After the last request of the frame is accepted and every request has completed, `evt[0]` pulses high for exactly one cycle.
- R10: An `rsp_valid` strobe with `rsp_err` set during a fetch pulses `evt[1]` for one cycle. No new request is raised from the next cycle onward. `evt[0]` still pulses once every outstanding request has completed.
- R11: A `frame_start` pulse that arrives while a fetch or its drain is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Frame start address |
| cfg_line_len | input | LEN_W | Bytes fetched per line |
| cfg_pitch | input | LEN_W | Address step between line starts |
| cfg_line_cnt | input | CNT_W | Lines per frame minus one |
| cfg_bus_opt | input | 12 | [4:0] one-hot burst size, [11:8] outstanding limit |
| frame_start | input | 1 | Frame start pulse from the timing generator |
| req_valid | output | 1 | Read request present |
| req_addr | output | ADDR_W | Request byte address |
| req_beats | output | 5 | Beats in this request, 1 to 16 |
| req_grant | input | 1 | Request accepted this cycle |
| rsp_valid | input | 1 | One request completed |
| rsp_err | input | 1 | The completion carries a bus error |
| evt | output | 2 | Event pulses: bit0 fetch done, bit1 bus error |

## Verification
The bench builds the block with a 32-bit address, 12-bit line fields, 6-bit line count and 4-byte beats. With these values, short lines of a few beats exercise every burst size, the shortened tail bursts and line wrap within a few hundred cycles per frame. Outstanding limits from 0 to 15 are reachable, so the bench, which grants and completes requests at random times, pushes the outstanding count against the limit. Directed frames cover multi-bit burst selects, a start address changed and a frame start pulsed in the middle of a fetch, and an error on an early completion.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } fsc_state_e;

  localparam int BEATS_W = 5;
  localparam int OPT_W   = 12;

  // Highest set select bit wins; an empty select means single beats.
  function automatic logic [BEATS_W-1:0] sel_to_beats(input logic [4:0] sel);
    logic [BEATS_W-1:0] b;
    b = 5'd1;
    for (int i = 0; i < 5; i++) begin
      if (sel[i]) b = 5'(1 << i);
    end
    return b;
  endfunction

endpackage

// File: rtl/fsc_bus_opt.sv
module fsc_bus_opt
  import fsc_pkg::*;
(
  input  logic [OPT_W-1:0]   bus_opt,
  output logic [BEATS_W-1:0] burst_beats,
  output logic [BEATS_W-1:0] out_limit
);

  logic [3:0] lim_field;

  assign lim_field   = bus_opt[11:8];
  assign burst_beats = sel_to_beats(bus_opt[4:0]);
  // A zero limit would stall forever; it is treated as one.
  assign out_limit   = (lim_field == 4'd0) ? 5'd1 : {1'b0, lim_field};

endmodule

// File: rtl/fsc_credit.sv
module fsc_credit
  import fsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic               retire,
  input  logic [BEATS_W-1:0] limit,
  output logic               can_issue,
  output logic               idle
);

  logic [BEATS_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = issue ^ retire;
    cnt_d  = cnt_q;
    if (issue && !retire)      cnt_d = cnt_q + 5'd1;
    else if (!issue && retire) cnt_d = cnt_q - 5'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign can_issue = (cnt_q < limit);
  assign idle      = (cnt_q == '0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (cnt_q < limit));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (cnt_q != '0));

endmodule

// File: rtl/fsc_walker.sv
module fsc_walker
  import fsc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 12,
  parameter int BEAT_SH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [ADDR_W-1:0]  base,
  input  logic [LEN_W-1:0]   line_len,
  input  logic [LEN_W-1:0]   pitch,
  input  logic [CNT_W-1:0]   line_cnt,
  input  logic [BEATS_W-1:0] burst_beats,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [BEATS_W-1:0] cur_beats,
  output logic               last_req
);

  logic [ADDR_W-1:0] line_addr_q, line_addr_d;
  logic [ADDR_W-1:0] cur_addr_q,  cur_addr_d;
  logic [LEN_W-1:0]  len_beats_q, len_beats_d;
  logic [LEN_W-1:0]  left_q,      left_d;
  logic [LEN_W-1:0]  pitch_q,     pitch_d;
  logic [CNT_W-1:0]  lines_q,     lines_d;
  logic              line_end;
  logic              walk_en;

  always_comb begin
    if (left_q < LEN_W'(burst_beats)) cur_beats = left_q[BEATS_W-1:0];
    else                              cur_beats = burst_beats;
  end

  assign line_end = (left_q == LEN_W'(cur_beats));
  assign last_req = line_end && (lines_q == '0);
  assign walk_en  = load | step;

  always_comb begin
    line_addr_d = line_addr_q;
    cur_addr_d  = cur_addr_q;
    len_beats_d = len_beats_q;
    left_d      = left_q;
    pitch_d     = pitch_q;
    lines_d     = lines_q;
    if (load) begin
      line_addr_d = base;
      cur_addr_d  = base;
      len_beats_d = line_len >> BEAT_SH;
      left_d      = line_len >> BEAT_SH;
      pitch_d     = pitch;
      lines_d     = line_cnt;
    end else if (step) begin
      if (line_end) begin
        if (lines_q != '0) begin
          line_addr_d = line_addr_q + ADDR_W'(pitch_q);
          cur_addr_d  = line_addr_q + ADDR_W'(pitch_q);
          left_d      = len_beats_q;
          lines_d     = lines_q - 1'b1;
        end else begin
          left_d      = '0;
        end
      end else begin
        cur_addr_d = cur_addr_q + (ADDR_W'(cur_beats) << BEAT_SH);
        left_d     = left_q - LEN_W'(cur_beats);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_addr_q <= '0;
      cur_addr_q  <= '0;
      len_beats_q <= '0;
      left_q      <= '0;
      pitch_q     <= '0;
      lines_q     <= '0;
    end else if (walk_en) begin
      line_addr_q <= line_addr_d;
      cur_addr_q  <= cur_addr_d;
      len_beats_q <= len_beats_d;
      left_q      <= left_d;
      pitch_q     <= pitch_d;
      lines_q     <= lines_d;
    end
  end

  assign cur_addr = cur_addr_q;

  p_tail_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (LEN_W'(cur_beats) <= left_q));

  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && line_end && lines_q != '0) |=> (cur_addr_q == $past(line_addr_q) + ADDR_W'($past(pitch_q))));

endmodule

// File: rtl/fb_scan_fetch.sv
module fb_scan_fetch
  import fsc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 12,
  parameter int BEAT_SH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_line_len,
  input  logic [LEN_W-1:0]   cfg_pitch,
  input  logic [CNT_W-1:0]   cfg_line_cnt,
  input  logic [OPT_W-1:0]   cfg_bus_opt,
  input  logic               frame_start,
  output logic               req_valid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BEATS_W-1:0] req_beats,
  input  logic               req_grant,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  output logic [1:0]         evt
);

  fsc_state_e         state_q, state_d;
  logic [BEATS_W-1:0] burst_beats;
  logic [BEATS_W-1:0] out_limit;
  logic               can_issue;
  logic               credit_idle;
  logic               issue;
  logic               load;
  logic               last_req;
  logic               bus_err;
  logic               evt_end_q, evt_end_d;
  logic               evt_err_q, evt_err_d;

  fsc_bus_opt u_opt (
    .bus_opt     (cfg_bus_opt),
    .burst_beats (burst_beats),
    .out_limit   (out_limit)
  );

  fsc_credit u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .retire    (rsp_valid),
    .limit     (out_limit),
    .can_issue (can_issue),
    .idle      (credit_idle)
  );

  fsc_walker #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W),
    .BEAT_SH (BEAT_SH)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .step        (issue),
    .base        (cfg_base),
    .line_len    (cfg_line_len),
    .pitch       (cfg_pitch),
    .line_cnt    (cfg_line_cnt),
    .burst_beats (burst_beats),
    .cur_addr    (req_addr),
    .cur_beats   (req_beats),
    .last_req    (last_req)
  );

  assign req_valid = (state_q == ST_FETCH) && can_issue;
  assign issue     = req_valid && req_grant;
  assign load      = (state_q == ST_IDLE) && frame_start;
  assign bus_err   = rsp_valid && rsp_err && (state_q != ST_IDLE);

  always_comb begin
    state_d   = state_q;
    evt_end_d = 1'b0;
    evt_err_d = bus_err;
    case (state_q)
      ST_IDLE:  if (frame_start) state_d = ST_FETCH;
      ST_FETCH: if (bus_err || (issue && last_req)) state_d = ST_DRAIN;
      ST_DRAIN: if (credit_idle) begin
                  state_d   = ST_IDLE;
                  evt_end_d = 1'b1;
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      evt_end_q <= 1'b0;
      evt_err_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      evt_end_q <= evt_end_d;
      evt_err_q <= evt_err_d;
    end
  end

  assign evt = {evt_err_q, evt_end_q};

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_grant && !bus_err) |=> (req_valid && $stable(req_addr) && $stable(req_beats)));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !req_valid);

  p_burst_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0 && req_beats <= burst_beats));

  p_end_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> (credit_idle && !req_valid));

  p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> !evt[0]);

endmodule

// File: tb/sim_fb_scan_fetch.sv
module sim_fb_scan_fetch;

  localparam int AW = 32;
  localparam int LW = 12;
  localparam int CW = 6;
  localparam int SH = 2;
  localparam int MAXR = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_line_len = '0;
  logic [LW-1:0] cfg_pitch = '0;
  logic [CW-1:0] cfg_line_cnt = '0;
  logic [11:0]   cfg_bus_opt = '0;
  logic          frame_start = 1'b0;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [4:0]    req_beats;
  logic          req_grant = 1'b0;
  logic          rsp_valid = 1'b0;
  logic          rsp_err = 1'b0;
  logic [1:0]    evt;

  int n_chk = 0;
  int n_fail = 0;
  int exp_n;
  logic [AW-1:0] exp_addr [MAXR];
  logic [4:0]    exp_beats [MAXR];
  logic [AW-1:0] got_addr [MAXR];
  logic [4:0]    got_beats [MAXR];

  always #10 clk = ~clk;

  fb_scan_fetch #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW), .BEAT_SH(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_line_len(cfg_line_len),
    .cfg_pitch(cfg_pitch), .cfg_line_cnt(cfg_line_cnt), .cfg_bus_opt(cfg_bus_opt),
    .frame_start(frame_start), .req_valid(req_valid), .req_addr(req_addr),
    .req_beats(req_beats), .req_grant(req_grant), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .evt(evt));

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int sel_beats(input logic [4:0] s);
    if (s[4]) return 16;
    if (s[3]) return 8;
    if (s[2]) return 4;
    if (s[1]) return 2;
    return 1;
  endfunction

  function automatic int lim_of(input logic [11:0] o);
    return (o[11:8] == 0) ? 1 : int'(o[11:8]);
  endfunction

  // Expected request list from R3, R4, R5, R6.
  function automatic void build_exp(input logic [AW-1:0] b, input int len, input int pit,
                                    input int lines, input logic [11:0] opt);
    int bb;
    bb = sel_beats(opt[4:0]);
    exp_n = 0;
    for (int l = 0; l < lines; l++) begin
      int left;
      logic [AW-1:0] a;
      left = len >> SH;
      a = b + AW'(l * pit);
      while (left > 0) begin
        int n;
        n = (left < bb) ? left : bb;
        exp_addr[exp_n]  = a;
        exp_beats[exp_n] = 5'(n);
        exp_n++;
        a = a + AW'(n << SH);
        left -= n;
      end
    end
  endfunction

  // Runs one frame as a randomly stalling bus slave.
  task automatic run_frame(input logic [AW-1:0] b, input int len, input int pit, input int cnt,
                           input logic [11:0] opt, input int err_idx, input int poke_cyc,
                           input logic [AW-1:0] poke_base, input string tag);
    int got_n, pend, maxp, rsp_n, ends, errs, err_cyc, cyc, lim, cmp_n;
    bit late_req, match;
    build_exp(b, len, pit, cnt + 1, opt);
    lim = lim_of(opt);
    got_n = 0; pend = 0; maxp = 0; rsp_n = 0; ends = 0; errs = 0; err_cyc = -1;
    late_req = 0;
    @(negedge clk);
    cfg_base = b; cfg_line_len = LW'(len); cfg_pitch = LW'(pit);
    cfg_line_cnt = CW'(cnt); cfg_bus_opt = opt; frame_start = 1'b1;
    for (cyc = 0; cyc < 20000; cyc++) begin
      bit g, r;
      @(negedge clk);
      frame_start = 1'b0;
      req_grant = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0;
      if (evt[0]) ends++;
      if (evt[1]) errs++;
      if (ends != 0) break;
      if (err_cyc >= 0 && cyc > err_cyc && req_valid) late_req = 1;
      if (cyc == poke_cyc) begin
        cfg_base = poke_base;
        frame_start = 1'b1;
      end
      g = req_valid && ($urandom % 4 != 0);
      r = (pend > 0) && ($urandom % 3 != 0);
      if (g && got_n < MAXR) begin
        got_addr[got_n] = req_addr;
        got_beats[got_n] = req_beats;
        got_n++;
      end
      if (r) begin
        rsp_valid = 1'b1;
        if (rsp_n == err_idx) begin
          rsp_err = 1'b1;
          err_cyc = cyc;
        end
        rsp_n++;
        pend--;
      end
      req_grant = g;
      if (g) pend++;
      if (pend > maxp) maxp = pend;
    end
    req_grant = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; frame_start = 1'b0;
    @(negedge clk);
    chk(evt == 2'b00, {tag, " R9 end pulse one cycle"}, evt, 0);
    match = 1;
    cmp_n = (got_n < exp_n) ? got_n : exp_n;
    for (int i = 0; i < cmp_n; i++) begin
      if (match && (got_addr[i] != exp_addr[i] || got_beats[i] != exp_beats[i])) begin
        match = 0;
        $display("FAIL %s R3/R5/R6 request %0d: got %0h/%0d expected %0h/%0d",
                 tag, i, got_addr[i], got_beats[i], exp_addr[i], exp_beats[i]);
      end
    end
    n_chk++;
    if (!match) n_fail++;
    if (err_idx < 0) begin
      chk(got_n == exp_n, {tag, " R4 request count"}, got_n, exp_n);
      chk(errs == 0, {tag, " R10 no error event"}, errs, 0);
    end else begin
      chk(errs == 1, {tag, " R10 error event"}, errs, 1);
      chk(!late_req, {tag, " R10 no request after error"}, late_req, 0);
      chk(got_n < exp_n, {tag, " R10 fetch cut short"}, got_n, exp_n);
    end
    chk(ends == 1, {tag, " R9 end event"}, ends, 1);
    chk(pend == 0, {tag, " R9 all returned before end"}, pend, 0);
    chk(maxp <= lim, {tag, " R7 outstanding limit"}, maxp, lim);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R1 no request in reset", req_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R1 idle after reset", req_valid, 0);
    chk(evt == 2'b00, "R1 no events after reset", evt, 0);

    // R3 R4 R6: 10-beat lines in bursts of 4, pitch larger than length.
    run_frame(32'h1000, 40, 64, 2, 12'h204, -1, -1, '0, "d1");
    // R5 R7: empty select gives single beats; zero limit acts as one.
    run_frame(32'h2000, 12, 12, 0, 12'h000, -1, -1, '0, "d2");
    // R5: several select bits, the highest (16) wins; tail of 4.
    run_frame(32'h3000, 80, 96, 1, 12'hF1A, -1, -1, '0, "d3");
    // R2 R11: base changed and frame start pulsed mid-fetch.
    run_frame(32'h4000, 64, 64, 3, 12'h302, -1, 6, 32'h9000, "d4");
    // R2: the next frame takes the new base.
    run_frame(32'h9000, 16, 16, 0, 12'h302, -1, -1, '0, "d4b");
    // R10: error on the third completion.
    run_frame(32'h5000, 64, 64, 4, 12'h402, 2, -1, '0, "d5");

    for (int k = 0; k < 10; k++) begin
      int len, pit, cnt;
      logic [11:0] opt;
      logic [AW-1:0] b;
      len = (1 + $urandom % 24) << SH;
      pit = len + (($urandom % 8) << SH);
      cnt = $urandom % 6;
      opt = {($urandom % 16) & 4'hF, 3'b000, 5'($urandom % 32)};
      b   = ($urandom % 32'h10000) & ~32'h3;
      run_frame(b, len, pit, cnt, opt, -1, -1, '0, "rnd");
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule